// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block screens received frames by destination address. The six address bytes arrive one per valid cycle, first-transmitted byte first. While they arrive, the block folds them into a bit-reflected CRC-32. After the last byte, the top eight bits of the CRC register select one bit of a 256-bit filter table. The table is held as sixteen 16-bit words, and software loads it one word at a time through a small write port.

Two configuration inputs set the policy. The promiscuous input accepts every frame. The hash-enable input decides whether multicast addresses are judged by the table. The block gives one accept/reject result per address, as a single-cycle strobe. Exact matching of station addresses happens elsewhere, so a unicast address is always rejected here unless promiscuous mode is on.

Top module: `mhash_filter`

## Requirements
- R1: While reset is asserted and after it is released, `dec_valid` and `dec_accept` are low until an address has completed.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the sixth byte of an address is taken; `dec_accept` is low whenever `dec_valid` is low.
- R3: The hash is a CRC-32 over the six bytes in arrival order, least significant bit of each byte first. It starts from 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320 and has no final inversion. The table index is bits 31:24 of the CRC register after the last byte.
- R4: Index bits 7:4 choose table word k, and index bits 3:0 choose bit n of that word. Word k is loaded by asserting `tbl_wr_en` with `tbl_wr_idx` = k and the data on `tbl_wr_data`; bit n of the data is bit n of the word. All words clear to zero at reset.
- R5: With `cfg_promisc` = 1 at the sixth byte, the address is accepted whatever the table holds and whether or not it is multicast.
- R6: With `cfg_promisc` = 0 and `cfg_hash_en` = 1, a multicast address is accepted exactly when its table bit is 1. An address is multicast when bit 0 of its first byte is 1.
- R7: With `cfg_promisc` = 0 and `cfg_hash_en` = 0, multicast addresses are rejected.
- R8: With `cfg_promisc` = 0, unicast addresses (bit 0 of the first byte is 0) are rejected.
- R9: With all sixteen words set to 0xFFFF and hash filtering on, every multicast address is accepted.
- R10: A byte marked by `addr_first` starts a new address and abandons any partial one. Valid bytes that come before any first marker, or after the sixth byte and before the next marker, are ignored and produce no decision.
- R11: Cycles with `addr_valid` low between bytes pause the address without changing the result.
- R12: A table write in the same cycle as the sixth byte does not affect that decision, which uses the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | An address byte is present this cycle |
| addr_first | input | 1 | The present byte is the first of an address |
| addr_byte | input | 8 | Address byte |
| cfg_promisc | input | 1 | Accept every address |
| cfg_hash_en | input | 1 | Judge multicast addresses by the table |
| tbl_wr_en | input | 1 | Write one table word |
| tbl_wr_idx | input | 4 | Table word number |
| tbl_wr_data | input | 16 | Table word value |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Accept (1) or reject (0), valid with the strobe |

## Verification
A list of vectors sends multicast, broadcast and unicast addresses under every setting of the two configuration inputs, against an irregular table pattern. This separates the promiscuous path, the hash path and the two rejection paths. Directed tests set a single table bit, then every bit except that one, then the same bit in a neighbouring word. These show that the word select and the bit select come from the correct halves of the CRC byte. The stream tests cover idle gaps, restarts in the middle of an address, trailing extra bytes and stray bytes before the first marker, which check the byte counting. A write in the same cycle as the decision shows that the lookup uses the table contents from before the write.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int CRC_W = 32;

   // One byte of reflected CRC, least significant bit first.
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic [7:0]       b,
                                                 input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] r;
      r = c ^ {{(CRC_W-8){1'b0}}, b};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
   import mhf_pkg::*;
#(
   parameter int               ADDR_BYTES = 6,
   parameter int               IDX_W      = 8,
   parameter logic [CRC_W-1:0] POLY       = 32'hEDB88320,
   parameter logic [CRC_W-1:0] SEED       = 32'hFFFFFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid_i,
   input  logic             byte_first_i,
   input  logic [7:0]       byte_i,
   output logic             done_o,
   output logic             mcast_o,
   output logic [IDX_W-1:0] index_o
);
   localparam int              CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

   logic [CNT_W-1:0] cnt_q;
   logic [CRC_W-1:0] crc_q;
   logic             mc_q;
   logic             take;
   logic [CRC_W-1:0] crc_base;
   logic [CRC_W-1:0] crc_nxt;

   // a byte counts if it opens an address or continues an open one
   assign take     = byte_valid_i && (byte_first_i || (cnt_q != '0 && cnt_q != FULL));
   assign crc_base = byte_first_i ? SEED : crc_q;
   assign crc_nxt  = crc_step(crc_base, byte_i, POLY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         crc_q <= '0;
         mc_q  <= 1'b0;
      end else if (take) begin
         crc_q <= crc_nxt;
         if (byte_first_i) begin
            cnt_q <= CNT_W'(1);
            mc_q  <= byte_i[0];
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   generate
      if (ADDR_BYTES == 1) begin : g_single
         assign done_o = byte_valid_i && byte_first_i;
      end else begin : g_multi
         assign done_o = take && !byte_first_i && (cnt_q == LAST);
      end
   endgenerate

   assign mcast_o = byte_first_i ? byte_i[0] : mc_q;
   assign index_o = crc_nxt[CRC_W-1 -: IDX_W];

   a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
   parameter int IDX_W  = 8,
   parameter int WORD_W = 16,
   localparam int BSEL_W = $clog2(WORD_W),
   localparam int WSEL_W = IDX_W - BSEL_W,
   localparam int NWORDS = 2 ** WSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [WSEL_W-1:0] wr_idx_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  look_idx_i,
   output logic              hit_o
);
   logic [NWORDS-1:0][WORD_W-1:0] words;

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      logic [WORD_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            w_q <= '0;
         else if (wr_en_i && wr_idx_i == WSEL_W'(g))
            w_q <= wr_data_i;
      end
      assign words[g] = w_q;
   end

   logic [WSEL_W-1:0] wsel;
   logic [BSEL_W-1:0] bsel;
   logic [WORD_W-1:0] picked;

   assign wsel   = look_idx_i[IDX_W-1 -: WSEL_W];
   assign bsel   = look_idx_i[BSEL_W-1:0];
   assign picked = words[wsel];
   assign hit_o  = picked[bsel];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic promisc_i,
   input  logic hash_en_i,
   input  logic mcast_i,
   input  logic hit_i,
   output logic valid_o,
   output logic accept_o
);
   logic verdict;

   always_comb begin
      if (promisc_i)
         verdict = 1'b1;
      else if (mcast_i && hash_en_i)
         verdict = hit_i;
      else
         verdict = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         accept_o <= 1'b0;
      end else begin
         valid_o  <= done_i;
         accept_o <= done_i && verdict;
      end
   end

   a_r5_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && promisc_i |=> valid_o && accept_o);
   a_r7_hash_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && !promisc_i && !hash_en_i |=> valid_o && !accept_o);
   a_r8_unicast_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && !promisc_i && !mcast_i |=> !accept_o);
   a_r2_quiet_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> !accept_o);
endmodule

// File: rtl/mhash_filter.sv
module mhash_filter
   import mhf_pkg::*;
#(
   parameter int               ADDR_BYTES = 6,
   parameter int               IDX_W      = 8,
   parameter int               WORD_W     = 16,
   parameter logic [CRC_W-1:0] POLY       = 32'hEDB88320,
   parameter logic [CRC_W-1:0] SEED       = 32'hFFFFFFFF,
   localparam int BSEL_W = $clog2(WORD_W),
   localparam int WSEL_W = IDX_W - BSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_valid,
   input  logic              addr_first,
   input  logic [7:0]        addr_byte,
   input  logic              cfg_promisc,
   input  logic              cfg_hash_en,
   input  logic              tbl_wr_en,
   input  logic [WSEL_W-1:0] tbl_wr_idx,
   input  logic [WORD_W-1:0] tbl_wr_data,
   output logic              dec_valid,
   output logic              dec_accept
);
   generate
      if (ADDR_BYTES < 1) begin : g_chk_bytes
         $error("ADDR_BYTES must be at least 1");
      end
      if ((WORD_W & (WORD_W - 1)) != 0 || WORD_W < 2) begin : g_chk_word
         $error("WORD_W must be a power of two of at least 2");
      end
      if (IDX_W > CRC_W || IDX_W <= BSEL_W) begin : g_chk_idx
         $error("IDX_W must exceed the bit-select width and fit the CRC");
      end
   endgenerate

   logic             done;
   logic             mcast;
   logic [IDX_W-1:0] index;
   logic             hit;

   mhf_crc_acc #(
      .ADDR_BYTES(ADDR_BYTES),
      .IDX_W     (IDX_W),
      .POLY      (POLY),
      .SEED      (SEED)
   ) u_crc (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_valid_i(addr_valid),
      .byte_first_i(addr_first),
      .byte_i      (addr_byte),
      .done_o      (done),
      .mcast_o     (mcast),
      .index_o     (index)
   );

   mhf_table #(
      .IDX_W (IDX_W),
      .WORD_W(WORD_W)
   ) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (tbl_wr_en),
      .wr_idx_i  (tbl_wr_idx),
      .wr_data_i (tbl_wr_data),
      .look_idx_i(index),
      .hit_o     (hit)
   );

   mhf_decide u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (done),
      .promisc_i(cfg_promisc),
      .hash_en_i(cfg_hash_en),
      .mcast_i  (mcast),
      .hit_i    (hit),
      .valid_o  (dec_valid),
      .accept_o (dec_accept)
   );

   a_r2_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(addr_valid));
endmodule

// File: tb/tb_mhash_filter.sv
`timescale 1ns/1ps
module tb_mhash_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_valid = 1'b0;
   logic        addr_first = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic        cfg_promisc = 1'b0;
   logic        cfg_hash_en = 1'b0;
   logic        tbl_wr_en = 1'b0;
   logic [3:0]  tbl_wr_idx = '0;
   logic [15:0] tbl_wr_data = '0;
   logic        dec_valid;
   logic        dec_accept;

   int total = 0;
   int bad   = 0;
   logic [15:0] model [16];

   always #2 clk = ~clk;

   mhash_filter dut (
      .clk(clk), .rst_n(rst_n),
      .addr_valid(addr_valid), .addr_first(addr_first), .addr_byte(addr_byte),
      .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
      .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   // address {pr, he}; first-sent byte is bits 47:40
   localparam logic [49:0] VEC [12] = '{
      {48'h01005E000001, 1'b0, 1'b1},
      {48'h333300000001, 1'b0, 1'b1},
      {48'hFFFFFFFFFFFF, 1'b0, 1'b1},
      {48'h0180C2000000, 1'b0, 1'b1},
      {48'h09002B00000F, 1'b0, 1'b1},
      {48'h01005E7FFFFA, 1'b0, 1'b1},
      {48'h001122334455, 1'b0, 1'b1},
      {48'h01005E000001, 1'b0, 1'b0},
      {48'hFFFFFFFFFFFF, 1'b0, 1'b0},
      {48'h001122334455, 1'b1, 1'b0},
      {48'h0180C2000000, 1'b1, 1'b1},
      {48'h020000000000, 1'b0, 1'b0}
   };

   function automatic logic [7:0] hash_of(input logic [47:0] a);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int k = 0; k < 6; k++) begin
         for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = c[0] ^ a[47 - 8*k - 7 + b];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
         end
      end
      return c[31:24];
   endfunction

   function automatic logic expect_of(input logic [47:0] a, input logic pr, input logic he);
      logic [7:0] h;
      logic [15:0] w;
      h = hash_of(a);
      w = model[h[7:4]];
      if (pr) return 1'b1;
      if (!a[40]) return 1'b0;
      if (!he) return 1'b0;
      return w[h[3:0]];
   endfunction

   task automatic chk(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_word(input int k, input logic [15:0] d);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 4'(k); tbl_wr_data = d;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      model[k] = d;
   endtask

   // drive bytes 0..5; gap inserts idle cycles; leaves the last byte driven
   task automatic send(input logic [47:0] a, input int gap);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         addr_valid = 1'b1; addr_first = (k == 0); addr_byte = a[47 - 8*k -: 8];
         if (gap > 0 && k < 5) begin
            @(negedge clk);
            chk(dec_valid == 1'b0, "R11 no strobe mid-address", 32'(dec_valid), 0);
            addr_valid = 1'b0;
            for (int g = 1; g < gap; g++) @(negedge clk);
         end
      end
   endtask

   // after the last byte: strobe in the next cycle only
   task automatic finish_and_check(input logic exp, input string tag);
      @(negedge clk);
      addr_valid = 1'b0; addr_first = 1'b0;
      chk(dec_valid == 1'b1, {tag, " strobe"}, 32'(dec_valid), 1);
      chk(dec_accept == exp, {tag, " accept"}, 32'(dec_accept), 32'(exp));
      @(negedge clk);
      chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R2 one-cycle strobe", 32'(dec_valid), 0);
   endtask

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0]  h;
      logic [47:0] mca;
      for (int k = 0; k < 16; k++) model[k] = '0;
      repeat (3) @(negedge clk);
      chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R1 during reset", 32'(dec_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R1 after reset", 32'(dec_valid), 0);

      // R10: stray bytes before any first marker
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         addr_valid = 1'b1; addr_first = 1'b0; addr_byte = 8'(k * 37);
         @(negedge clk);
         chk(dec_valid == 1'b0, "R10 stray byte ignored", 32'(dec_valid), 0);
      end
      addr_valid = 1'b0;

      // irregular table pattern, R4 write path
      for (int k = 0; k < 16; k++) wr_word(k, 16'(k * 16'h1357) ^ 16'hA5A5);

      // vector walk: R3 R5 R6 R7 R8
      for (int v = 0; v < 12; v++) begin
         cfg_promisc = VEC[v][1];
         cfg_hash_en = VEC[v][0];
         send(VEC[v][49:2], 0);
         finish_and_check(expect_of(VEC[v][49:2], VEC[v][1], VEC[v][0]),
                          "R3 R5 R6 R7 R8 vector");
      end

      // R4: only the target bit set
      mca = 48'h01005E0000FB;
      h = hash_of(mca);
      cfg_promisc = 1'b0; cfg_hash_en = 1'b1;
      for (int k = 0; k < 16; k++) wr_word(k, 16'h0000);
      wr_word(h[7:4], 16'h1 << h[3:0]);
      send(mca, 0);
      finish_and_check(1'b1, "R4 single bit");
      wr_word(h[7:4], ~(16'h1 << h[3:0]));
      send(mca, 0);
      finish_and_check(1'b0, "R4 all but bit");
      wr_word(h[7:4], 16'h0000);
      wr_word((h[7:4] + 4'd1), 16'h1 << h[3:0]);
      send(mca, 0);
      finish_and_check(1'b0, "R4 neighbour word");

      // R9: all ones
      for (int k = 0; k < 16; k++) wr_word(k, 16'hFFFF);
      for (int v = 0; v < 6; v++) begin
         send(VEC[v][49:2], 0);
         finish_and_check(1'b1, "R9 all-ones table");
      end
      // R7 still rejects with full table
      cfg_hash_en = 1'b0;
      send(48'h333300000001, 0);
      finish_and_check(1'b0, "R7 hash off full table");
      cfg_hash_en = 1'b1;

      // R10: restart mid-address, then trailing extra bytes
      for (int k = 0; k < 16; k++) wr_word(k, 16'h0000);
      h = hash_of(mca);
      wr_word(h[7:4], 16'h1 << h[3:0]);
      send(48'h0100AAAAAAAA, 0);   // abandoned after being restarted below
      addr_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         addr_valid = 1'b1; addr_first = (k == 0); addr_byte = 8'h01 + 8'(k);
      end
      send(mca, 0);
      finish_and_check(1'b1, "R10 restart");
      // first address of this group gave its own strobe already inside send? check trailing
      send(mca, 0);
      @(negedge clk);
      addr_first = 1'b0; addr_byte = 8'h55;
      chk(dec_valid == 1'b1 && dec_accept == 1'b1, "R10 decision before extras", 32'(dec_valid), 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(dec_valid == 1'b0, "R10 extra byte ignored", 32'(dec_valid), 0);
      end
      addr_valid = 1'b0;

      // R11: gaps between bytes
      send(mca, 3);
      finish_and_check(1'b1, "R11 gapped address");

      // R12: write in the sixth-byte cycle
      wr_word(h[7:4], 16'h0000);
      send(mca, 0);
      tbl_wr_en = 1'b1; tbl_wr_idx = h[7:4]; tbl_wr_data = 16'hFFFF;
      model[h[7:4]] = 16'hFFFF;
      finish_and_check(1'b0, "R12 old contents used");
      tbl_wr_en = 1'b0;
      send(mca, 0);
      finish_and_check(1'b1, "R12 write landed");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule